// File: doc/BRIEF.md
# Quarter-Segment Piecewise Global Gain

This block applies one gain curve to a stream of pixel codes. The curve is the same for every colour. The input code range is cut into four equal quarters, and each quarter has its own 5-bit slope register. A slope code `g` gives a gain of `(g + 1) / 16` inside its quarter, so the gain can be set from 1/16 up to 2 in steps of 1/16. The quarters are chained. The output of a quarter starts where the output of the quarter below it ends, so the transfer curve has no jumps even when neighbouring slopes differ. The gain can therefore rise or fall with signal level, for example to lift shadows and compress highlights.

Software writes slopes into a staging set of registers at any time. The staging set moves into the active set only on a frame-start strobe, together with the per-quarter starting offsets, which are recomputed from the staged slopes. A whole frame is therefore processed with one consistent curve. A curve-override input, sampled with each pixel, makes that pixel pass through unchanged. It keeps the same two-cycle latency, so it can be switched per pixel without disturbing the stream timing.

Top module: `quad_gain_curve`

## Requirements
- R1: While reset is low, and after reset is released, `out_valid` is 0 and `out_code` is 0. Both the staged and the active slopes reset to code 15, which is unity gain, so the output equals the input until new slopes are made active.
- R2: A pixel accepted on a rising edge with `in_valid` high appears on `out_valid`/`out_code` two rising edges later. `out_valid` is high exactly for those cycles. On cycles with `out_valid` low, `out_code` keeps its previous value.
- R3: The quarter is chosen by input bits [9:8]: 0 is the lowest quarter, 3 is the highest. Bits [7:0] are the offset inside the quarter. `cfg_wr_sel` value k addresses the slope of quarter k.
- R4: With the override low, the output is floor(S / 16) for each pixel. S is the sum of 256*(g_k + 1) over all quarters k below the pixel's quarter q, plus offset*(g_q + 1). The same curve applies to every pixel, whatever its colour. An input code of 0 always gives 0.
- R5: Results above 1023 are clamped to 1023.
- R6: A pixel accepted with `curve_off` high is output equal to its input code, with the same two-cycle latency.
- R7: A write (`cfg_wr_en` high) changes only the staged slope. Pixels keep using the active slopes until an edge where `frame_start` is high copies the staged set into the active set. A pixel accepted on that same edge still uses the previous active slopes. A write on that same edge is not included in the copy.
- R8: Slope code 0 gives gain 1/16 and code 31 gives gain 2. For example, an input of 255 in quarter 0 gives 15 with code 0 and 510 with code 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Writes `cfg_wr_gain` into the staged slope of quarter `cfg_wr_sel` |
| cfg_wr_sel | input | 2 | Quarter addressed by the write |
| cfg_wr_gain | input | 5 | Slope code; gain is (code+1)/16 |
| frame_start | input | 1 | Moves staged slopes and recomputed offsets into the active set |
| curve_off | input | 1 | Per-pixel override: pass the pixel through unchanged |
| in_valid | input | 1 | Input pixel qualifier |
| in_code | input | 10 | Input pixel code |
| out_valid | output | 1 | Output pixel qualifier |
| out_code | output | 10 | Output pixel code |

## Verification
The assertions that look two cycles back assume that both pipeline stages have been clocked with reset high. They are therefore gated until two edges after reset release. The zero-input and pass-through properties rely only on the port values two edges earlier. The stimulus always drives every input to a defined level from time zero and changes inputs only on falling edges. Frame-start strobes, slope writes and override changes are mixed with valid pixels, so that pixels land right on quarter boundaries, on the frame-start edge itself, and between gaps in `in_valid`.

// File: rtl/qgc_pkg.sv
// Shared constants for the quarter-segment gain curve.
// Assumes the code range is always split into exactly four segments.
package qgc_pkg;
    localparam int QGC_SEGS  = 4;
    localparam int QGC_SEL_W = 2;
endpackage

// File: rtl/qgc_gain_bank.sv
// Staged and active slope registers, plus the per-segment starting offsets.
// Starting offsets are prefix sums of full-segment contributions, kept in
// 1/2^FRAC_W units, and they are latched only on frame_start.
// Assumes a synchronous active-low reset.
module qgc_gain_bank
    import qgc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int GAIN_W = 5,
    parameter int FRAC_W = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [QGC_SEL_W-1:0]                  wr_sel,
    input  logic [GAIN_W-1:0]                     wr_gain,
    input  logic                                  frame_start,
    output logic [QGC_SEGS-1:0][GAIN_W-1:0]       act_gain,
    output logic [QGC_SEGS-1:0][DATA_W+GAIN_W-1:0] act_base
);
    localparam int OFF_W = DATA_W - QGC_SEL_W;
    localparam int ACC_W = DATA_W + GAIN_W;
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'((1 << FRAC_W) - 1);

    logic [QGC_SEGS-1:0][GAIN_W-1:0] stg_gain;
    logic [QGC_SEGS-1:0][ACC_W-1:0]  base_nxt;

    assign base_nxt[0] = '0;

    for (genvar k = 0; k < QGC_SEGS; k++) begin : g_seg
        // Staged slope: written by the configuration port at any time.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg_gain[k] <= UNITY;
            else if (wr_en && (wr_sel == QGC_SEL_W'(k)))
                stg_gain[k] <= wr_gain;
        end

        // Active slope and start offset: replaced only at frame start.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_gain[k] <= UNITY;
                act_base[k] <= ACC_W'(k) << (OFF_W + FRAC_W);
            end else if (frame_start) begin
                act_gain[k] <= stg_gain[k];
                act_base[k] <= base_nxt[k];
            end
        end

        if (k > 0) begin : g_pref
            // Prefix sum: previous start plus a full previous segment.
            assign base_nxt[k] = base_nxt[k-1]
                               + ((ACC_W'(stg_gain[k-1]) + ACC_W'(1)) << OFF_W);
        end
    end
endmodule

// File: rtl/qgc_pipe.sv
// Two-stage datapath. Stage 1 selects the segment and forms
// start + offset * slope in fractional units. Stage 2 drops the fraction,
// clamps, and applies the per-pixel override.
// Assumes the active gains and bases are stable between frame starts.
module qgc_pipe
    import qgc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int GAIN_W = 5,
    parameter int FRAC_W = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [QGC_SEGS-1:0][GAIN_W-1:0]        act_gain,
    input  logic [QGC_SEGS-1:0][DATA_W+GAIN_W-1:0] act_base,
    input  logic                                   curve_off,
    input  logic                                   in_valid,
    input  logic [DATA_W-1:0]                      in_code,
    output logic                                   out_valid,
    output logic [DATA_W-1:0]                      out_code
);
    localparam int OFF_W = DATA_W - QGC_SEL_W;
    localparam int ACC_W = DATA_W + GAIN_W;
    localparam int SC_W  = ACC_W - FRAC_W;
    localparam logic [SC_W-1:0] MAXC = SC_W'((1 << DATA_W) - 1);

    logic [QGC_SEL_W-1:0] sel;
    logic [OFF_W-1:0]     off;
    logic [ACC_W-1:0]     prod;
    logic                 s1_vld, s1_byp;
    logic [DATA_W-1:0]    s1_raw;
    logic [ACC_W-1:0]     s1_sum;
    logic [SC_W-1:0]      scaled;
    logic [DATA_W-1:0]    clamped;

    assign sel  = in_code[DATA_W-1 -: QGC_SEL_W];
    assign off  = in_code[OFF_W-1:0];
    assign prod = ACC_W'(off) * (ACC_W'(act_gain[sel]) + ACC_W'(1));

    // Stage 1 qualifier: tracks the input valid every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_vld <= 1'b0;
        else        s1_vld <= in_valid;
    end

    // Stage 1 data: loaded only with an accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_byp <= 1'b0;
            s1_raw <= '0;
            s1_sum <= '0;
        end else if (in_valid) begin
            s1_byp <= curve_off;
            s1_raw <= in_code;
            s1_sum <= act_base[sel] + prod;
        end
    end

    assign scaled  = s1_sum[ACC_W-1:FRAC_W];
    assign clamped = (scaled > MAXC) ? '1 : scaled[DATA_W-1:0];

    // Stage 2 qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s1_vld;
    end

    // Stage 2 data: holds its value on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_code <= '0;
        else if (s1_vld) out_code <= s1_byp ? s1_raw : clamped;
    end
endmodule

// File: rtl/quad_gain_curve.sv
// Top level: piecewise global gain over four equal code quarters.
// Slope writes are staged and take effect at frame_start. The pixel path
// has a fixed two-cycle latency, whether or not the override is active.
module quad_gain_curve
    import qgc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int GAIN_W = 5,
    parameter int FRAC_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [QGC_SEL_W-1:0] cfg_wr_sel,
    input  logic [GAIN_W-1:0]    cfg_wr_gain,
    input  logic                 frame_start,
    input  logic                 curve_off,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_code,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_code
);
    localparam int ACC_W = DATA_W + GAIN_W;

    logic [QGC_SEGS-1:0][GAIN_W-1:0] act_gain;
    logic [QGC_SEGS-1:0][ACC_W-1:0]  act_base;

    qgc_gain_bank #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_sel     (cfg_wr_sel),
        .wr_gain    (cfg_wr_gain),
        .frame_start(frame_start),
        .act_gain   (act_gain),
        .act_base   (act_base)
    );

    qgc_pipe #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_gain (act_gain),
        .act_base (act_base),
        .curve_off(curve_off),
        .in_valid (in_valid),
        .in_code  (in_code),
        .out_valid(out_valid),
        .out_code (out_code)
    );
endmodule

// File: rtl/qgc_checker.sv
// Port-level properties of quad_gain_curve, attached through bind.
// A small counter gates the two-cycle look-back until both pipeline
// stages have been clocked out of reset.
module qgc_checker #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              curve_off,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_code,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_code
);
    logic [1:0] cyc;
    logic       warm;

    // Count edges since reset release, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= 2'd0;
        else if (cyc != 2'd2) cyc <= cyc + 2'd1;
    end

    assign warm = (cyc == 2'd2);

    AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 2))); // R2

    AST_IDLE_HOLDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && !out_valid) |-> $stable(out_code)); // R2

    AST_OVERRIDE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(curve_off, 2)) |-> (out_code == $past(in_code, 2))); // R6

    AST_ZERO_MAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && !$past(curve_off, 2) && $past(in_code, 2) == '0)
        |-> (out_code == '0)); // R4
endmodule

bind quad_gain_curve qgc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .curve_off(curve_off),
    .in_valid (in_valid),
    .in_code  (in_code),
    .out_valid(out_valid),
    .out_code (out_code)
);

// File: tb/quad_gain_curve_tb_top.sv
// Bench: a behavioural model advances on each rising edge, and the outputs
// are compared with it on every falling edge.
module quad_gain_curve_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_sel = 2'd0;
    logic [4:0] cfg_wr_gain = 5'd0;
    logic       frame_start = 1'b0;
    logic       curve_off = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_code = 10'd0;
    logic       out_valid;
    logic [9:0] out_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_gain_curve dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_gain(cfg_wr_gain), .frame_start(frame_start), .curve_off(curve_off),
        .in_valid(in_valid), .in_code(in_code), .out_valid(out_valid), .out_code(out_code)
    );

    // Reference model state
    int    stg[4];
    int    act[4];
    bit    p1v = 0;
    int    p1c = 0;
    string p1t = "R1";
    bit    ev = 0;
    int    ec = 0;
    string et = "R1";

    function automatic int raw_curve(int code);
        int q = code >> 8;
        int s = 0;
        for (int k = 0; k < q; k++) s += 256 * (act[k] + 1);
        s += (code & 255) * (act[q] + 1);
        return s / 16;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin stg[k] = 15; act[k] = 15; end
            p1v = 0; ev = 0; ec = 0;
        end else begin
            ev = p1v;
            if (p1v) begin ec = p1c; et = p1t; end
            p1v = in_valid;
            if (in_valid) begin
                if (curve_off) begin
                    p1c = int'(in_code); p1t = "R6";
                end else begin
                    p1c = raw_curve(int'(in_code));
                    p1t = tag;
                    if (p1c > 1023) begin p1c = 1023; p1t = "R5"; end
                end
            end
            if (frame_start) for (int k = 0; k < 4; k++) act[k] = stg[k];
            if (cfg_wr_en) stg[cfg_wr_sel] = int'(cfg_wr_gain);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (out_valid !== ev) begin
                errors++;
                $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, ev);
            end
            checks++;
            if (int'(out_code) != ec || $isunknown(out_code)) begin
                errors++;
                $display("FAIL %s out_code actual %0d expected %0d", ev ? et : "R2", out_code, ec);
            end
        end
    end

    task automatic pix(input int code, input bit byp = 0);
        in_valid = 1; in_code = 10'(code); curve_off = byp;
        @(negedge clk);
        in_valid = 0; curve_off = 0;
    endtask

    task automatic wr(input int sel, input int g);
        cfg_wr_en = 1; cfg_wr_sel = 2'(sel); cfg_wr_gain = 5'(g);
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic fs();
        frame_start = 1;
        @(negedge clk);
        frame_start = 0;
    endtask

    task automatic set_all(input int g);
        for (int k = 0; k < 4; k++) wr(k, g);
        fs();
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        checks++;
        if (out_valid !== 1'b0 || out_code !== 10'd0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %0b/%0d expected 0/0", out_valid, out_code);
        end
        rst_n = 1;
        @(negedge clk);
        tag = "R1";
        for (int c = 0; c < 1024; c += 37) pix(c); // unity curve from reset
        drain();

        tag = "R4";
        wr(0, 3); wr(1, 22); wr(2, 9); wr(3, 27); fs();
        for (int c = 0; c < 1024; c += 5) pix(c);
        drain();

        tag = "R8";
        set_all(0);
        pix(255); pix(1023); pix(0); pix(128);
        set_all(31);
        pix(255); pix(100); pix(300);
        drain();

        tag = "R3";
        wr(0, 31); wr(1, 0); wr(2, 7); wr(3, 20); fs();
        for (int c = 250; c < 263; c++) pix(c);
        for (int c = 508; c < 516; c++) pix(c);
        for (int c = 764; c < 772; c++) pix(c);
        pix(1023);
        drain();

        tag = "R5";
        set_all(31);
        for (int c = 400; c < 1024; c += 13) pix(c);
        drain();

        tag = "R6";
        for (int i = 0; i < 60; i++) pix(int'($urandom_range(1023)), i[0]);
        drain();

        tag = "R7";
        set_all(15);
        wr(2, 0); wr(0, 31);
        pix(100); pix(600);              // still unity
        in_valid = 1; in_code = 10'd600; frame_start = 1;
        cfg_wr_en = 1; cfg_wr_sel = 2'd3; cfg_wr_gain = 5'd0;
        @(negedge clk);                  // pixel on the copy edge: old curve
        in_valid = 0; frame_start = 0; cfg_wr_en = 0;
        pix(100); pix(600); pix(900);    // new curve, quarter 3 still unity
        fs();
        pix(900);                        // now quarter 3 at 1/16
        drain();

        tag = "R2";
        wr(0, 12); wr(1, 25); wr(2, 4); wr(3, 18); fs();
        for (int i = 0; i < 300; i++) begin
            in_valid = $urandom_range(1);
            in_code = 10'($urandom_range(1023));
            curve_off = ($urandom_range(7) == 0);
            @(negedge clk);
        end
        in_valid = 0; curve_off = 0;
        drain();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule